// File: doc/BRIEF.md
# Multi-Channel Match Timer Bank

This block holds eight match channels, each with a 32-bit counter, a 32-bit compare value and a small control word. The control word picks the rate the counter advances at from a set of externally generated strobes. It also picks whether the channel is compared against its own counter or a counter shared by its group, whether the counter clears when the channel fires, and whether the channel fires once or on every equality. Each channel produces a one-cycle match pulse. The status collection for those pulses belongs to a neighbouring base timer. The bank only condenses the upper status bits into one interrupt line.

Channels are known locally as 0 to 7. Local channels 0, 4 and 6 lead groups {0..3}, {4,5} and {6,7}. Channels 4 to 7 have a wider control word that adds a halt bit and a capture bit. Reading counter 5 or counter 7 with its capture bit set copies the group leader's counter into a capture register. Software accesses the bank over a simple word bus. Read data appears one cycle after the read strobe.

Top module: `match_timer_bank`

## Requirements
- R1: Word addresses decode as: counter j at 0x40+4j, compare value j at 0x80+4j, control j at 0xC0+4j, capture register at 0x20. `bus_rdata` is loaded on the clock edge that samples `bus_rd`. An unmapped address reads 0.
- R2: Control bits [2:0] pick the counting source. Code 1 selects `rate_stb[0]`, 2 selects `rate_stb[1]`, 3 selects `rate_stb[2]`, 4 selects `rate_stb[3]` and 5 selects `rate_stb[4]`. Codes 0, 6 and 7 hold the counter still. A running counter advances by one on each clock edge where its selected strobe is high.
- R3: A bus write to a counter loads it on the next edge. A counter wraps from 0xFFFFFFFF to 0.
- R4: A channel fires when its compared counter becomes equal to its compare value. Firing produces a one-cycle `match_pulse[j]` on the edge after the equality first appears. Writing the compare value arms the channel. With control bit 6 clear, the channel disarms after firing once.
- R5: With control bit 6 set, the channel stays armed and fires every time the equality reappears.
- R6: With control bit 3 set, firing clears the channel's own counter to zero on the edge that raises the pulse.
- R7: With control bit 7 set, a channel compares against its own counter. With bit 7 clear, channels 0-3 compare against counter 0, channels 4-5 against counter 4, and channels 6-7 against counter 6.
- R8: Leaders 0, 4 and 6 always count at their selected rate. A non-leader with bit 7 clear keeps its own counter still.
- R9: Control registers 0-3 keep bits [7:0] and read the rest as 0. Control registers 4-7 keep bits [9:0].
- R10: On channels 4-7, control bit 8 set holds the counter still regardless of bits [2:0].
- R11: A read of counter 5 with its control bit 9 set copies counter 4 into the capture register. A read of counter 7 with its control bit 9 set copies counter 6. Without bit 9, the capture register is left unchanged.
- R12: `irq_out` is the OR of `evt_status[11:4]`, registered one cycle. Bits [3:0] have no effect on it.
- R13: After reset, all counters, compare values, control words and the capture register are zero, every channel is disarmed, and no pulse or interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rate_stb | input | 5 | One-cycle rate strobes, index 0..4 |
| evt_status | input | 12 | Status bits from the base timer |
| match_pulse | output | 8 | One-cycle match pulse per channel |
| irq_out | output | 1 | Combined interrupt for status bits 11:4 |

## Verification
The assertions assume `bus_wr` and `bus_rd` are never both high, and that reads and writes use word-aligned mapped addresses. The hold properties for stopped counters also rely on each strobe being a clean level sampled once per edge. The stimulus drives every bus access and strobe at the falling edge for exactly one cycle, so each transaction is seen by a single rising edge. It never overlaps a read with a write. Status inputs change only outside reset, so the interrupt property sees a defined previous value.

// File: rtl/mtb_pkg.sv
`timescale 1ns/1ps
package mtb_pkg;
  localparam int OFS_SNAP  = 'h20;
  localparam int OFS_CNT   = 'h40;
  localparam int OFS_MATCH = 'h80;
  localparam int OFS_CTRL  = 'hC0;

  localparam int B_RST  = 3;
  localparam int B_PER  = 6;
  localparam int B_OWN  = 7;
  localparam int B_HALT = 8;
  localparam int B_SNAP = 9;

  // group leader of local channel j
  function automatic int grp_leader(int j);
    if (j < 4) return 0;
    else if (j < 6) return 4;
    else return 6;
  endfunction

  // channels with the wide control word
  function automatic bit is_wide(int j);
    return j >= 4;
  endfunction

  // channels whose counter read can capture the leader
  function automatic bit has_snap(int j);
    return (j == 5) || (j == 7);
  endfunction
endpackage

// File: rtl/mtb_channel.sv
`timescale 1ns/1ps
module mtb_channel
  import mtb_pkg::*;
#(
  parameter int CW        = 32,
  parameter int CTRLW     = 10,
  parameter int NRATE     = 5,
  parameter bit IS_LEADER = 1'b0,
  parameter bit WIDE      = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NRATE-1:0] rate_stb,
  input  logic             ctrl_we,
  input  logic             cnt_we,
  input  logic             match_we,
  input  logic [CW-1:0]    wdata,
  input  logic [CW-1:0]    lead_cnt,
  output logic [CW-1:0]    cnt_o,
  output logic [CTRLW-1:0] ctrl_o,
  output logic [CW-1:0]    match_o,
  output logic             pulse_o
);
  localparam logic [CTRLW-1:0] KEEP = WIDE ? {CTRLW{1'b1}}
                                           : {{(CTRLW-8){1'b0}}, 8'hFF};

  logic [CW-1:0]    cnt_q, match_q, cmp;
  logic [CTRLW-1:0] ctrl_q;
  logic             armed_q, eq_q, pulse_q;
  logic             rate_ok, halted, self_run, tick, eq, fire;

  always_comb begin
    rate_ok = 1'b0;
    for (int r = 0; r < NRATE; r++)
      if (int'(ctrl_q[2:0]) == r + 1) rate_ok = rate_stb[r];
    halted   = WIDE && ctrl_q[B_HALT];
    self_run = IS_LEADER || ctrl_q[B_OWN];
    tick     = self_run && !halted && rate_ok;
    cmp      = self_run ? cnt_q : lead_cnt;
    eq       = (cmp == match_q);
    fire     = armed_q && eq && !eq_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      match_q <= '0;
      ctrl_q  <= '0;
      armed_q <= 1'b0;
      eq_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= wdata[CTRLW-1:0] & KEEP;
      if (match_we) begin
        match_q <= wdata;
        armed_q <= 1'b1;
      end else if (fire && !ctrl_q[B_PER]) begin
        armed_q <= 1'b0;
      end
      eq_q <= match_we ? 1'b0 : eq;
      if (cnt_we)                        cnt_q <= wdata;
      else if (fire && ctrl_q[B_RST])    cnt_q <= '0;
      else if (tick)                     cnt_q <= cnt_q + 1'b1;
      pulse_q <= fire;
    end
  end

  assign cnt_o   = cnt_q;
  assign ctrl_o  = ctrl_q;
  assign match_o = match_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/mtb_regif.sv
`timescale 1ns/1ps
module mtb_regif
  import mtb_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int CW    = 32,
  parameter int AW    = 8,
  parameter int CTRLW = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [AW-1:0]              bus_addr,
  input  logic [NCH-1:0][CW-1:0]     cnt_all,
  input  logic [NCH-1:0][CTRLW-1:0]  ctrl_all,
  input  logic [NCH-1:0][CW-1:0]     match_all,
  output logic [NCH-1:0]             ctrl_we,
  output logic [NCH-1:0]             cnt_we,
  output logic [NCH-1:0]             match_we,
  output logic [CW-1:0]              rdata_o
);
  logic [CW-1:0] rd_mux, snap_q, rdata_q;

  always_comb begin
    ctrl_we  = '0;
    cnt_we   = '0;
    match_we = '0;
    rd_mux   = '0;
    if (bus_addr == AW'(OFS_SNAP)) rd_mux = snap_q;
    for (int j = 0; j < NCH; j++) begin
      if (bus_addr == AW'(OFS_CNT + 4*j)) begin
        cnt_we[j] = bus_wr;
        rd_mux    = cnt_all[j];
      end
      if (bus_addr == AW'(OFS_MATCH + 4*j)) begin
        match_we[j] = bus_wr;
        rd_mux      = match_all[j];
      end
      if (bus_addr == AW'(OFS_CTRL + 4*j)) begin
        ctrl_we[j] = bus_wr;
        rd_mux     = CW'(ctrl_all[j]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q  <= '0;
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rd_mux;
      for (int j = 1; j < NCH; j++)
        if (has_snap(j) && bus_addr == AW'(OFS_CNT + 4*j) && ctrl_all[j][B_SNAP])
          snap_q <= cnt_all[j-1];
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/mtb_irq.sv
`timescale 1ns/1ps
module mtb_irq #(
  parameter int NSTAT   = 12,
  parameter int STAT_LO = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSTAT-1:0] stat,
  output logic             irq_o
);
  logic irq_q;
  logic unused_low;

  assign unused_low = ^stat[STAT_LO-1:0];

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |stat[NSTAT-1:STAT_LO];
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/match_timer_bank.sv
`timescale 1ns/1ps
module match_timer_bank
  import mtb_pkg::*;
#(
  parameter int CW      = 32,
  parameter int AW      = 8,
  parameter int NCH     = 8,
  parameter int CTRLW   = 10,
  parameter int NRATE   = 5,
  parameter int NSTAT   = 12,
  parameter int STAT_LO = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [CW-1:0]    bus_wdata,
  output logic [CW-1:0]    bus_rdata,
  input  logic [NRATE-1:0] rate_stb,
  input  logic [NSTAT-1:0] evt_status,
  output logic [NCH-1:0]   match_pulse,
  output logic             irq_out
);
  logic [NCH-1:0][CW-1:0]    cnt_all;
  logic [NCH-1:0][CW-1:0]    match_all;
  logic [NCH-1:0][CTRLW-1:0] ctrl_all;
  logic [NCH-1:0]            ctrl_we, cnt_we, match_we;

  mtb_regif #(.NCH(NCH), .CW(CW), .AW(AW), .CTRLW(CTRLW)) u_regif (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .cnt_all   (cnt_all),
    .ctrl_all  (ctrl_all),
    .match_all (match_all),
    .ctrl_we   (ctrl_we),
    .cnt_we    (cnt_we),
    .match_we  (match_we),
    .rdata_o   (bus_rdata)
  );

  for (genvar j = 0; j < NCH; j++) begin : g_ch
    localparam int LJ = grp_leader(j);
    mtb_channel #(
      .CW(CW), .CTRLW(CTRLW), .NRATE(NRATE),
      .IS_LEADER(LJ == j), .WIDE(is_wide(j))
    ) u_ch (
      .clk      (clk),
      .rst      (rst),
      .rate_stb (rate_stb),
      .ctrl_we  (ctrl_we[j]),
      .cnt_we   (cnt_we[j]),
      .match_we (match_we[j]),
      .wdata    (bus_wdata),
      .lead_cnt (cnt_all[LJ]),
      .cnt_o    (cnt_all[j]),
      .ctrl_o   (ctrl_all[j]),
      .match_o  (match_all[j]),
      .pulse_o  (match_pulse[j])
    );
  end

  mtb_irq #(.NSTAT(NSTAT), .STAT_LO(STAT_LO)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .stat  (evt_status),
    .irq_o (irq_out)
  );
endmodule

// File: rtl/mtb_checker.sv
`timescale 1ns/1ps
module mtb_checker
  import mtb_pkg::*;
#(
  parameter int CW      = 32,
  parameter int AW      = 8,
  parameter int NCH     = 8,
  parameter int CTRLW   = 10,
  parameter int NSTAT   = 12,
  parameter int STAT_LO = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_wr,
  input logic [AW-1:0]             bus_addr,
  input logic [CW-1:0]             bus_wdata,
  input logic [NSTAT-1:0]          evt_status,
  input logic [NCH-1:0]            match_pulse,
  input logic                      irq_out,
  input logic [NCH-1:0][CW-1:0]    cnt_all,
  input logic [NCH-1:0][CTRLW-1:0] ctrl_all
);
  a_r4_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (|match_pulse) |=> ((match_pulse & $past(match_pulse)) == '0));

  a_r12_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_out == (|$past(evt_status[NSTAT-1:STAT_LO]))));

  a_r13_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (match_pulse == '0 && !irq_out));

  for (genvar k = 0; k < NCH; k++) begin : g_k
    localparam logic [AW-1:0] CNT_A = AW'(OFS_CNT + 4*k);

    a_r3_load: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(bus_wr) && $past(bus_addr) == CNT_A)
        |-> cnt_all[k] == $past(bus_wdata));

    if (grp_leader(k) != k) begin : g_f
      a_r8_follower_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ctrl_all[k][B_OWN])
         && !($past(bus_wr) && $past(bus_addr) == CNT_A) && !match_pulse[k])
          |-> cnt_all[k] == $past(cnt_all[k]));
    end

    if (is_wide(k)) begin : g_w
      a_r10_halt_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ctrl_all[k][B_HALT])
         && !($past(bus_wr) && $past(bus_addr) == CNT_A) && !match_pulse[k])
          |-> cnt_all[k] == $past(cnt_all[k]));
    end
  end
endmodule

bind match_timer_bank mtb_checker #(
  .CW(CW), .AW(AW), .NCH(NCH), .CTRLW(CTRLW), .NSTAT(NSTAT), .STAT_LO(STAT_LO)
) u_mtb_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .evt_status  (evt_status),
  .match_pulse (match_pulse),
  .irq_out     (irq_out),
  .cnt_all     (cnt_all),
  .ctrl_all    (ctrl_all)
);

// File: tb/test_match_timer_bank.sv
`timescale 1ns/1ps
module test_match_timer_bank;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  rate_stb = '0;
  logic [11:0] evt_status = '0;
  logic [7:0]  match_pulse;
  logic        irq_out;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  int pcnt [NCH];

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t sbq[$];

  always #5 clk = ~clk;

  match_timer_bank i_match_timer_bank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rate_stb(rate_stb),
    .evt_status(evt_status), .match_pulse(match_pulse), .irq_out(irq_out)
  );

  function automatic logic [7:0] a_cnt(int j);   return 8'(8'h40 + 4*j); endfunction
  function automatic logic [7:0] a_match(int j); return 8'(8'h80 + 4*j); endfunction
  function automatic logic [7:0] a_ctrl(int j);  return 8'(8'hC0 + 4*j); endfunction

  always @(negedge clk)
    if (!rst)
      for (int k = 0; k < NCH; k++) if (match_pulse[k]) pcnt[k]++;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when read data becomes valid
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        e = sbq.pop_front();
        @(negedge clk);
        chk(e.tag, bus_rdata, e.exp);
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_exp(logic [7:0] a, logic [31:0] exp, string tag);
    exp_t e;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    e.exp = exp; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic tick(int r, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rate_stb[r] = 1'b1;
      @(negedge clk); rate_stb[r] = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R13 watchdog act=hung exp=finished");
      finish_run();
    end
  end

  initial begin
    int b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    chk("R13 pulses after reset", 32'(match_pulse), 0);
    chk("R13 irq after reset", 32'(irq_out), 0);
    rd_exp(a_ctrl(4), 0, "R13 ctrl4 reset");
    rd_exp(a_cnt(0), 0, "R13 cnt0 reset");
    rd_exp(a_match(7), 0, "R13 match7 reset");
    rd_exp(8'h20, 0, "R13 capture reset");
    // R1 map and unmapped
    wr(a_match(3), 32'hCAFE0003);
    rd_exp(a_match(3), 32'hCAFE0003, "R1 match3 readback");
    rd_exp(8'h00, 0, "R1 unmapped 0x00");
    rd_exp(8'h3C, 0, "R1 unmapped 0x3C");
    // R9 control widths
    wr(a_ctrl(1), 32'hFFFFFFFF);
    rd_exp(a_ctrl(1), 32'h000000FF, "R9 narrow ctrl");
    wr(a_ctrl(5), 32'hFFFFFFFF);
    rd_exp(a_ctrl(5), 32'h000003FF, "R9 wide ctrl");
    wr(a_ctrl(1), 0);
    wr(a_ctrl(5), 0);
    // R3 load and wrap, R2 source codes
    wr(a_ctrl(0), 32'h1);
    wr(a_cnt(0), 32'hFFFFFFFE);
    tick(0, 3);
    rd_exp(a_cnt(0), 32'h1, "R3 wrap");
    wr(a_ctrl(0), 32'h2);
    tick(0, 2);
    rd_exp(a_cnt(0), 32'h1, "R2 code2 ignores strobe0");
    tick(1, 3);
    rd_exp(a_cnt(0), 32'h4, "R2 code2 uses strobe1");
    wr(a_ctrl(0), 32'h5);
    tick(4, 2);
    rd_exp(a_cnt(0), 32'h6, "R2 code5 uses strobe4");
    wr(a_ctrl(0), 32'h6);
    for (int r = 0; r < 5; r++) tick(r, 1);
    rd_exp(a_cnt(0), 32'h6, "R2 code6 stopped");
    wr(a_ctrl(0), 32'h0);
    for (int r = 0; r < 5; r++) tick(r, 1);
    rd_exp(a_cnt(0), 32'h6, "R2 code0 stopped");
    // R4 one-shot
    wr(a_ctrl(0), 32'h1);
    wr(a_cnt(0), 0);
    wr(a_match(0), 3);
    b = pcnt[0];
    tick(0, 3); settle();
    chk("R4 one-shot fires", 32'(pcnt[0] - b), 1);
    wr(a_cnt(0), 0);
    tick(0, 3); settle();
    chk("R4 one-shot disarmed", 32'(pcnt[0] - b), 1);
    // R5 periodic with R6 clear
    wr(a_ctrl(0), 32'h49);
    wr(a_cnt(0), 0);
    wr(a_match(0), 2);
    b = pcnt[0];
    tick(0, 6); settle();
    chk("R5 periodic pulses", 32'(pcnt[0] - b), 3);
    rd_exp(a_cnt(0), 0, "R6 cleared on match");
    // periodic without clear
    wr(a_ctrl(0), 32'h41);
    wr(a_cnt(0), 0);
    wr(a_match(0), 2);
    b = pcnt[0];
    tick(0, 4); settle();
    chk("R5 no clear single equality", 32'(pcnt[0] - b), 1);
    rd_exp(a_cnt(0), 4, "R6 no clear keeps counting");
    // R7 shared group 0
    wr(a_ctrl(0), 32'h1);
    wr(a_cnt(0), 0);
    wr(a_ctrl(1), 0);
    wr(a_match(1), 5);
    b = pcnt[1];
    tick(0, 5); settle();
    chk("R7 ch1 follows counter0", 32'(pcnt[1] - b), 1);
    rd_exp(a_cnt(1), 0, "R8 follower counter held");
    // R7 own counter
    wr(a_ctrl(1), 32'h81);
    wr(a_cnt(1), 0);
    wr(a_match(1), 4);
    b = pcnt[1];
    tick(0, 4); settle();
    chk("R7 ch1 own counter fires", 32'(pcnt[1] - b), 1);
    rd_exp(a_cnt(1), 4, "R7 own counter runs");
    // R7 groups 4 and 6
    wr(a_ctrl(4), 32'h1);
    wr(a_cnt(4), 0);
    wr(a_ctrl(5), 0);
    wr(a_match(5), 2);
    b = pcnt[5];
    tick(0, 2); settle();
    chk("R7 ch5 follows counter4", 32'(pcnt[5] - b), 1);
    wr(a_ctrl(6), 32'h1);
    wr(a_cnt(6), 0);
    wr(a_ctrl(7), 0);
    wr(a_match(7), 3);
    b = pcnt[7];
    tick(0, 3); settle();
    chk("R7 ch7 follows counter6", 32'(pcnt[7] - b), 1);
    // R8 follower with a rate code but shared
    wr(a_ctrl(2), 32'h1);
    wr(a_cnt(2), 7);
    tick(0, 3);
    rd_exp(a_cnt(2), 7, "R8 shared follower stopped");
    // R10 halt bit
    wr(a_ctrl(4), 32'h101);
    wr(a_cnt(4), 0);
    tick(0, 3);
    rd_exp(a_cnt(4), 0, "R10 halt holds counter4");
    wr(a_ctrl(4), 32'h1);
    tick(0, 1);
    rd_exp(a_cnt(4), 1, "R10 release counts again");
    // R11 capture
    wr(a_ctrl(5), 32'h200);
    wr(a_cnt(4), 32'h1234);
    rd_exp(a_cnt(5), 0, "R11 counter5 value");
    rd_exp(8'h20, 32'h1234, "R11 capture of counter4");
    wr(a_ctrl(5), 0);
    wr(a_cnt(4), 32'h99);
    rd_exp(a_cnt(5), 0, "R11 counter5 value again");
    rd_exp(8'h20, 32'h1234, "R11 no capture without bit9");
    wr(a_ctrl(7), 32'h200);
    wr(a_cnt(6), 32'hABC);
    rd_exp(a_cnt(7), 0, "R11 counter7 value");
    rd_exp(8'h20, 32'hABC, "R11 capture of counter6");
    // R12 interrupt combine
    @(negedge clk); evt_status = 12'h00F;
    settle();
    chk("R12 low bits ignored", 32'(irq_out), 0);
    @(negedge clk); evt_status = 12'h800;
    @(negedge clk);
    chk("R12 high bit raises irq", 32'(irq_out), 1);
    @(negedge clk); evt_status = 12'h000;
    @(negedge clk);
    chk("R12 irq clears", 32'(irq_out), 0);

    wait (sbq.size() == 0);
    settle();
    done = 1'b1;
    finish_run();
  end
endmodule